// File: doc/BRIEF.md
# Packed SIMD Lane Shifter

This unit shifts a 128-bit operand either as a set of independent lanes or as one whole register. In lane mode the operand is split into eight 16-bit, four 32-bit or two 64-bit lanes. Every lane is shifted by the same count: logically left, logically right, or arithmetically right. The arithmetic mode is available only on 16-bit and 32-bit lanes. In whole-register mode the 128-bit value moves left or right by a whole number of bytes, and zeros enter from the vacated end.

The lane count comes either from an 8-bit immediate or from a 64-bit count operand, which is the low half of a second vector register. Counts at or beyond the lane width are well defined. A logical shift then clears the lane, and an arithmetic shift fills the lane with its sign bit. Operation and width combinations that have no meaning raise an illegal flag and return zero. A build parameter places an output register after the datapath. It is enabled by default, which gives one cycle of latency.

Top module: `packed_lane_shifter`

## Requirements
- R1: `lane_i` picks the lane width: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit. Lane n occupies bits [n*W+W-1 : n*W].
- R2: Operation code 0 is a logical left shift of every lane, with zeros entering at each lane's bit 0. A count of 0 returns the operand unchanged.
- R3: Operation code 1 is a logical right shift of every lane, with zeros entering at each lane's top bit.
- R4: Operation code 2 is an arithmetic right shift on 16-bit or 32-bit lanes. Each lane's top bit is copied into the vacated positions, and each lane's top bit is preserved.
- R5: When `cnt_src_i` = 0 the lane count is `imm_i`, taken as unsigned. When `cnt_src_i` = 1 it is the full unsigned 64-bit `cnt_opnd_i`.
- R6: A logical lane shift whose count is greater than or equal to the lane width gives an all-zero lane.
- R7: An arithmetic lane shift whose count is greater than or equal to the lane width fills the lane with its sign bit.
- R8: Operation code 3 shifts the whole 128-bit value left by `imm_i` bytes, and operation code 4 shifts it right by `imm_i` bytes. Zero bytes fill the vacated end. These two operations ignore `lane_i` and `cnt_src_i`.
- R9: A byte shift with `imm_i` greater than 15 gives an all-zero result and is not illegal.
- R10: In lane operations no bit crosses a lane boundary.
- R11: The following combinations set `illegal_o` and force `result_o` to zero: operation 2 with 64-bit lanes, operation codes 5 to 7, and `lane_i` = 3 on a lane operation.
- R12: With `REG_OUT` = 1, `result_o` and `illegal_o` reflect the inputs sampled at the previous rising edge. A synchronous active-low reset clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation: 0 shl, 1 shr, 2 sar, 3 byte left, 4 byte right |
| lane_i | input | 2 | Lane width select (0: 16, 1: 32, 2: 64) |
| cnt_src_i | input | 1 | Count source: 0 immediate, 1 count operand |
| imm_i | input | 8 | Immediate count, in bits for lane operations and in bytes for byte shifts |
| cnt_opnd_i | input | 64 | Count operand, the low half of the second vector |
| data_i | input | 128 | Operand to be shifted |
| result_o | output | 128 | Shifted result |
| illegal_o | output | 1 | Unsupported operation or width combination |

## Verification
On every cycle the assertions check the combinational result ahead of the output register. They check that an illegal combination yields zero and that 64-bit arithmetic shifts are flagged. They check that over-range byte shifts clear the result, and that a zero immediate count passes the operand through unchanged. On 16-bit lanes they check that arithmetic shifts keep each sign bit and that left shifts by a nonzero count clear each lane's bit 0. They also check that reset clears the outputs.

Exact values are shown only by the bench's scenarios. These cover the results for each lane width and direction, the saturation of large 64-bit counts, byte movement across lane boundaries, and the one-cycle output timing.

// File: rtl/lane_shift_pkg.sv
// Package: shared encodings for the packed lane shifter.
// Assumes: operation and lane encodings are fixed by the block's requirements.
package lane_shift_pkg;

    typedef enum logic [2:0] {
        OP_SHL    = 3'd0,
        OP_SHR    = 3'd1,
        OP_SAR    = 3'd2,
        OP_BYTE_L = 3'd3,
        OP_BYTE_R = 3'd4
    } shift_op_e;

    typedef enum logic [1:0] {
        LANE_16 = 2'd0,
        LANE_32 = 2'd1,
        LANE_64 = 2'd2,
        LANE_RSV = 2'd3
    } lane_sel_e;

    // Lane-mode kind handed to each bank (low two bits of the op code)
    typedef enum logic [1:0] {
        KIND_SHL = 2'd0,
        KIND_SHR = 2'd1,
        KIND_SAR = 2'd2,
        KIND_NONE = 2'd3
    } lane_kind_e;

endpackage

// File: rtl/shift_count_sel.sv
// Module: shift_count_sel
// Picks the lane shift count from the immediate or the count operand and
// saturates it into CNT_W bits. Any value of 2**(CNT_W-1) or above is at least
// the widest lane, so clamping to the all-ones code keeps the over-range
// meaning while the banks compare narrow values only.
// Assumes: CNT_W-1 >= log2(widest lane) and IMM_W, OPND_W > CNT_W.
module shift_count_sel #(
    parameter int IMM_W  = 8,
    parameter int OPND_W = 64,
    parameter int CNT_W  = 7
) (
    input  logic              use_opnd_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OPND_W-1:0] opnd_i,
    output logic [CNT_W-1:0]  cnt_sat_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic imm_big;
    logic opnd_big;

    // Detect counts that do not fit the saturated width
    always_comb begin
        imm_big  = |imm_i[IMM_W-1:CNT_W];
        opnd_big = |opnd_i[OPND_W-1:CNT_W];
    end

    // Select the source, then clamp
    always_comb begin
        if (use_opnd_i) begin
            cnt_sat_o = opnd_big ? CNT_MAX : opnd_i[CNT_W-1:0];
        end else begin
            cnt_sat_o = imm_big ? CNT_MAX : imm_i[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/lane_shift_bank.sv
// Module: lane_shift_bank
// Splits the operand into DATA_W/LANE_W lanes and shifts each one on its own.
// The kinds are logical left, logical right and arithmetic right. A count of
// LANE_W or more clears the lane, or fills it with the sign bit for the
// arithmetic kind. KIND_NONE gives zero.
// Assumes: LANE_W is a power of two dividing DATA_W; CNT_W holds LANE_W.
module lane_shift_bank
    import lane_shift_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LANE_W = 16,
    parameter int CNT_W  = 7
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  lane_kind_e        kind_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int NLANE = DATA_W / LANE_W;
    localparam int AMT_W = $clog2(LANE_W);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(LANE_W);

    logic             over;
    logic [AMT_W-1:0] amt;

    // Shared over-range test and in-range amount for all lanes
    always_comb begin
        over = (cnt_i >= WIDTH_CNT);
        amt  = cnt_i[AMT_W-1:0];
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] src;
        logic [LANE_W-1:0] sign_fill;
        logic [LANE_W-1:0] res;

        assign src       = data_i[g*LANE_W +: LANE_W];
        assign sign_fill = {LANE_W{src[LANE_W-1]}};

        // Per-lane shift with saturation handling
        always_comb begin
            unique case (kind_i)
                KIND_SHL: res = over ? '0 : (src << amt);
                KIND_SHR: res = over ? '0 : (src >> amt);
                KIND_SAR: res = over ? sign_fill
                                     : LANE_W'($signed(src) >>> amt);
                default:  res = '0;
            endcase
        end

        assign data_o[g*LANE_W +: LANE_W] = res;
    end

endmodule

// File: rtl/byte_shift_unit.sv
// Module: byte_shift_unit
// Moves the whole operand left or right by a number of bytes and fills the
// vacated bytes with zeros. Byte counts beyond the last byte give zero.
// Assumes: DATA_W is a multiple of 8 and a power of two.
module byte_shift_unit #(
    parameter int DATA_W = 128,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              right_i,
    input  logic [IMM_W-1:0]  bytes_i,
    output logic [DATA_W-1:0] data_o
);

    localparam int NBYTES = DATA_W / 8;
    localparam int BSEL_W = $clog2(NBYTES);
    localparam int BIT_W  = BSEL_W + 3;
    localparam logic [IMM_W-1:0] LAST_BYTE = IMM_W'(NBYTES - 1);

    logic             too_far;
    logic [BIT_W-1:0] bit_amt;

    // Range test and conversion from bytes to bits
    always_comb begin
        too_far = (bytes_i > LAST_BYTE);
        bit_amt = {bytes_i[BSEL_W-1:0], 3'b000};
    end

    // Directional shift with zero fill
    always_comb begin
        if (too_far) begin
            data_o = '0;
        end else if (right_i) begin
            data_o = data_i >> bit_amt;
        end else begin
            data_o = data_i << bit_amt;
        end
    end

endmodule

// File: rtl/packed_lane_shifter.sv
// Module: packed_lane_shifter (top)
// 128-bit packed shifter with lane banks of 16, 32 and 64 bits and a
// whole-register byte shifter. An optional output register follows.
// Illegal combinations return zero and raise illegal_o.
// Assumes: inputs are stable around the clock edge; REG_OUT=0 gives a purely
// combinational path, and clk and rst_n are then unused.
module packed_lane_shifter
    import lane_shift_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int MIN_LANE = 16,
    parameter int NUM_WID  = 3,
    parameter int IMM_W    = 8,
    parameter int OPND_W   = 64,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        lane_i,
    input  logic              cnt_src_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [OPND_W-1:0] cnt_opnd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);

    localparam int MAX_LANE = MIN_LANE << (NUM_WID - 1);
    localparam int CNT_W    = $clog2(MAX_LANE) + 1;

    shift_op_e          op;
    lane_sel_e          lane;
    lane_kind_e         kind;
    logic               lane_op;
    logic               byte_op;
    logic [CNT_W-1:0]   cnt_sat;
    logic [DATA_W-1:0]  bank_res [NUM_WID];
    logic [DATA_W-1:0]  lane_res;
    logic [DATA_W-1:0]  byte_res;
    logic [DATA_W-1:0]  res_nx;
    logic               ill_nx;

    // Decode the operation into lane/byte class and legality
    always_comb begin
        op      = shift_op_e'(op_i);
        lane    = lane_sel_e'(lane_i);
        lane_op = (op_i <= 3'(OP_SAR));
        byte_op = (op == OP_BYTE_L) || (op == OP_BYTE_R);
        ill_nx  = !(lane_op || byte_op)
                || (lane_op && (lane == LANE_RSV))
                || ((op == OP_SAR) && (lane == LANE_64));
        kind    = lane_op ? lane_kind_e'(op_i[1:0]) : KIND_NONE;
    end

    shift_count_sel #(
        .IMM_W (IMM_W),
        .OPND_W(OPND_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .use_opnd_i(cnt_src_i),
        .imm_i     (imm_i),
        .opnd_i    (cnt_opnd_i),
        .cnt_sat_o (cnt_sat)
    );

    for (genvar w = 0; w < NUM_WID; w++) begin : g_bank
        lane_shift_bank #(
            .DATA_W(DATA_W),
            .LANE_W(MIN_LANE << w),
            .CNT_W (CNT_W)
        ) u_bank (
            .data_i(data_i),
            .cnt_i (cnt_sat),
            .kind_i(kind),
            .data_o(bank_res[w])
        );
    end

    byte_shift_unit #(
        .DATA_W(DATA_W),
        .IMM_W (IMM_W)
    ) u_byte (
        .data_i (data_i),
        .right_i(op == OP_BYTE_R),
        .bytes_i(imm_i),
        .data_o (byte_res)
    );

    // Choose the bank that matches the selected lane width
    always_comb begin
        lane_res = '0;
        for (int w = 0; w < NUM_WID; w++) begin
            if (32'(lane_i) == w) begin
                lane_res = bank_res[w];
            end
        end
    end

    // Final result selection with the illegal override
    always_comb begin
        if (ill_nx) begin
            res_nx = '0;
        end else if (byte_op) begin
            res_nx = byte_res;
        end else begin
            res_nx = lane_res;
        end
    end

    if (REG_OUT) begin : g_reg
        logic [DATA_W-1:0] res_q;
        logic              ill_q;

        // Output register with synchronous active-low reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                ill_q <= 1'b0;
            end else begin
                res_q <= res_nx;
                ill_q <= ill_nx;
            end
        end

        assign result_o  = res_q;
        assign illegal_o = ill_q;
    end else begin : g_comb
        assign result_o  = res_nx;
        assign illegal_o = ill_nx;
    end

endmodule

// File: rtl/lane_shifter_checker.sv
// Module: lane_shifter_checker
// Property checks on the shifter's pre-register result and its outputs.
// It is bound into packed_lane_shifter below.
// Assumes: 16-bit lanes are the narrowest width, at lane code 0.
module lane_shifter_checker #(
    parameter int DATA_W  = 128,
    parameter int IMM_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [1:0]        lane_i,
    input logic              cnt_src_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] data_i,
    input logic [DATA_W-1:0] res_nx,
    input logic              ill_nx,
    input logic [DATA_W-1:0] result_o,
    input logic              illegal_o
);

    localparam int N16 = DATA_W / 16;

    // R11: an illegal request never leaks data
    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ill_nx |-> (res_nx == '0));

    // R11: arithmetic shift on 64-bit lanes is flagged
    assert_sar64_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && lane_i == 2'd2) |-> ill_nx);

    // R9: byte shift beyond the last byte clears the result, legally
    assert_byte_far_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd3 || op_i == 3'd4) && imm_i > IMM_W'(15))
        |-> (res_nx == '0 && !ill_nx));

    // R2: zero immediate count on a legal logical lane shift is identity
    assert_zero_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd0 || op_i == 3'd1) && lane_i != 2'd3
         && !cnt_src_i && imm_i == '0) |-> (res_nx == data_i));

    for (genvar k = 0; k < N16; k++) begin : g_l16
        // R4: sign bit of every 16-bit lane survives an arithmetic shift
        assert_sar_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd2 && lane_i == 2'd0)
            |-> (res_nx[k*16+15] == data_i[k*16+15]));

        // R10: left shift by a nonzero count clears bit 0 of each lane
        assert_shl_lsb_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == 3'd0 && lane_i == 2'd0 && !cnt_src_i && imm_i != '0)
            |-> (res_nx[k*16] == 1'b0));
    end

    if (REG_OUT) begin : g_rst
        // R12: reset clears the registered outputs
        assert_reset_clear_R12: assert property (@(posedge clk)
            !rst_n |=> (result_o == '0 && !illegal_o));
    end

endmodule

bind packed_lane_shifter lane_shifter_checker #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .lane_i   (lane_i),
    .cnt_src_i(cnt_src_i),
    .imm_i    (imm_i),
    .data_i   (data_i),
    .res_nx   (res_nx),
    .ill_nx   (ill_nx),
    .result_o (result_o),
    .illegal_o(illegal_o)
);

// File: tb/sim_packed_lane_shifter.sv
`timescale 1ns/1ps
module sim_packed_lane_shifter;

    typedef struct packed {
        logic [2:0]   op;
        logic [1:0]   lane;
        logic         src;
        logic [7:0]   imm;
        logic [63:0]  cnt;
        logic [127:0] data;
        logic [127:0] exp;
        logic         ill;
        logic [7:0]   req;
    } vec_t;

    localparam logic [127:0] D16 = 128'h0001_8001_FFFF_1234_0000_000F_F00F_00FF;
    localparam logic [127:0] D32 = 128'h8000_0001_1234_5678_FFFF_FFFF_00AB_CDEF;
    localparam logic [127:0] D64 = 128'h8000_0000_0000_0001_0123_4567_89AB_CDEF;
    localparam logic [127:0] DB  = 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF;
    localparam int NV = 21;

    // Stimulus and expected results; req names the requirement (Rn)
    localparam vec_t TBL [NV] = '{
        // R2 shl 16 by 4
        '{3'd0, 2'd0, 1'b0, 8'd4, 64'd0, D16,
          128'h0010_0010_FFF0_2340_0000_00F0_00F0_0FF0, 1'b0, 8'd2},
        // R3 shr 16 by 4
        '{3'd1, 2'd0, 1'b0, 8'd4, 64'd0, D16,
          128'h0000_0800_0FFF_0123_0000_0000_0F00_000F, 1'b0, 8'd3},
        // R4 sar 16 by 4
        '{3'd2, 2'd0, 1'b0, 8'd4, 64'd0, D16,
          128'h0000_F800_FFFF_0123_0000_0000_FF00_000F, 1'b0, 8'd4},
        // R1 shl 32 by 8
        '{3'd0, 2'd1, 1'b0, 8'd8, 64'd0, D32,
          128'h0000_0100_3456_7800_FFFF_FF00_ABCD_EF00, 1'b0, 8'd1},
        // R5 sar 32 by register count 31
        '{3'd2, 2'd1, 1'b1, 8'd0, 64'd31, D32,
          128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000, 1'b0, 8'd5},
        // R7 sar 32 by huge register count
        '{3'd2, 2'd1, 1'b1, 8'd3, 64'h1_0000_0000, D32,
          128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000, 1'b0, 8'd7},
        // R3 shr 64 by 4
        '{3'd1, 2'd2, 1'b0, 8'd4, 64'd0, D64,
          128'h0800_0000_0000_0000_0012_3456_789A_BCDE, 1'b0, 8'd3},
        // R5 shl 64 by register count 63
        '{3'd0, 2'd2, 1'b1, 8'd0, 64'd63, D64,
          128'h8000_0000_0000_0000_8000_0000_0000_0000, 1'b0, 8'd5},
        // R6 shl 64 by register count 64
        '{3'd0, 2'd2, 1'b1, 8'd0, 64'd64, D64, 128'd0, 1'b0, 8'd6},
        // R6 shr 16 by 16
        '{3'd1, 2'd0, 1'b0, 8'd16, 64'd0, D16, 128'd0, 1'b0, 8'd6},
        // R5 register count 4 used even with a large immediate
        '{3'd1, 2'd0, 1'b1, 8'd200, 64'd4, D16,
          128'h0000_0800_0FFF_0123_0000_0000_0F00_000F, 1'b0, 8'd5},
        // R8 byte left 3
        '{3'd3, 2'd0, 1'b0, 8'd3, 64'd0, DB,
          128'h3344_5566_7788_99AA_BBCC_DDEE_FF00_0000, 1'b0, 8'd8},
        // R8 byte right 5
        '{3'd4, 2'd0, 1'b0, 8'd5, 64'd0, DB,
          128'h0000_0000_0000_1122_3344_5566_7788_99AA, 1'b0, 8'd8},
        // R9 byte right 16
        '{3'd4, 2'd0, 1'b0, 8'd16, 64'd0, DB, 128'd0, 1'b0, 8'd9},
        // R8 byte left 15
        '{3'd3, 2'd1, 1'b0, 8'd15, 64'd0, DB,
          128'hFF00_0000_0000_0000_0000_0000_0000_0000, 1'b0, 8'd8},
        // R8 byte left 1 ignores lane code 3 and register source
        '{3'd3, 2'd3, 1'b1, 8'd1, 64'd9, DB,
          128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF00, 1'b0, 8'd8},
        // R11 sar on 64-bit lanes
        '{3'd2, 2'd2, 1'b0, 8'd1, 64'd0, D64, 128'd0, 1'b1, 8'd11},
        // R11 op code 5
        '{3'd5, 2'd0, 1'b0, 8'd1, 64'd0, D16, 128'd0, 1'b1, 8'd11},
        // R11 lane code 3 on a lane op
        '{3'd0, 2'd3, 1'b0, 8'd1, 64'd0, D16, 128'd0, 1'b1, 8'd11},
        // R2 zero count is identity
        '{3'd0, 2'd0, 1'b0, 8'd0, 64'd0, D16, D16, 1'b0, 8'd2},
        // R7 sar 16 by 200
        '{3'd2, 2'd0, 1'b0, 8'd200, 64'd0, D16,
          128'h0000_FFFF_FFFF_0000_0000_0000_FFFF_0000, 1'b0, 8'd7}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = '0;
    logic [1:0]   lane_i = '0;
    logic         cnt_src_i = 1'b0;
    logic [7:0]   imm_i = '0;
    logic [63:0]  cnt_opnd_i = '0;
    logic [127:0] data_i = '0;
    logic [127:0] result_o;
    logic         illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    packed_lane_shifter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .lane_i    (lane_i),
        .cnt_src_i (cnt_src_i),
        .imm_i     (imm_i),
        .cnt_opnd_i(cnt_opnd_i),
        .data_i    (data_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    task automatic check(input string req, input logic [127:0] exp_r,
                         input logic exp_i);
        checks++;
        if (result_o !== exp_r || illegal_o !== exp_i) begin
            errors++;
            $display("FAIL %s result=%h illegal=%b expected result=%h illegal=%b",
                     req, result_o, illegal_o, exp_r, exp_i);
        end
    endtask

    task automatic drive(input vec_t v);
        op_i       = v.op;
        lane_i     = v.lane;
        cnt_src_i  = v.src;
        imm_i      = v.imm;
        cnt_opnd_i = v.cnt;
        data_i     = v.data;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 reset", 128'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].exp, TBL[i].ill);
        end

        // R12 latency: new inputs not visible before the next rising edge
        @(negedge clk);
        drive(TBL[0]);
        @(negedge clk);
        drive(TBL[1]);
        #2;
        check("R12 hold before edge", TBL[0].exp, 1'b0);
        @(negedge clk);
        check("R12 after edge", TBL[1].exp, 1'b0);

        // R10 single set bit at a 32-bit lane top does not leak to the next lane
        @(negedge clk);
        op_i = 3'd0; lane_i = 2'd1; cnt_src_i = 1'b0; imm_i = 8'd1;
        data_i = 128'h8000_0000_8000_0000_8000_0000_8000_0000;
        @(negedge clk);
        check("R10 no carry across lanes", 128'd0, 1'b0);

        // R12 reset clears a nonzero illegal output
        @(negedge clk);
        drive(TBL[16]);
        @(negedge clk);
        check("R11 before reset", 128'd0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset clears", 128'd0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule